// File: doc/BRIEF.md
# Write-Back Invalidation Coherence Controller

This block is the per-node coherence engine of a small direct-mapped write-back cache that shares a broadcast bus with other nodes. It stores a tag, a three-way line state (invalid, shared, exclusive) and one data word per line. It serves the local processor through a request/ready handshake. It also watches every transaction that other nodes put on the bus, so that at most one cache ever holds a writable, dirty copy of a line.

Processor reads that hit a valid line, and writes that hit an exclusive line, finish in the request cycle. Any other access raises a bus request and waits for the grant. The line is left untouched until the grant arrives. Once granted, the controller first writes back an exclusive victim that is held under a different tag, and then issues a read miss or a write miss. The fill, or the written word, is installed at that point. Snooped read or write misses that hit an exclusive line get the dirty word on the snoop data port in the same cycle, together with an abort flag that tells memory to stand down. Snooped write misses invalidate any copy. Snoop inputs are considered only while this node does not hold the grant.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is invalid, and `cpu_ready`, `bus_req` and `snp_abort` are low with `bus_cmd` at 00 (idle).
- R2: A read whose tag matches a shared or exclusive line returns the line word with `cpu_ready` high in the same cycle and no bus request. A read miss raises `bus_req`. In the granted cycle it drives `bus_cmd` = 01 with `bus_addr` = {tag, index}, where the index is the low log2(LINES) address bits. It installs `bus_fill` as a shared line and returns that word.
- R3: A write to a line that is not exclusive under the same tag (invalid, shared, or holding another tag) drives `bus_cmd` = 10 with the address once granted. The line becomes exclusive and holds the written word.
- R4: A write that hits an exclusive line completes in its request cycle with `bus_req` low and `bus_cmd` at 00, and it updates the stored word.
- R5: A snooped `snp_cmd` = 01 that hits an exclusive line raises `snp_abort` and drives the line word on `snp_data` in the same cycle. The line becomes shared.
- R6: A snooped `snp_cmd` = 10 that hits a shared or exclusive line makes it invalid. If the line was exclusive, `snp_abort` and `snp_data` behave as in R5.
- R7: A snoop with a different tag, a snooped 11 or 00, or a snooped 01 on a shared line leaves `snp_abort` low and the line state unchanged.
- R8: While waiting for `bus_gnt`, the controller issues no command and does not alter the line. Snoops that arrive during the wait are applied first, and the access is decided again from the line's new state when the grant comes.
- R9: A miss that displaces an exclusive line held under another tag first drives `bus_cmd` = 11 with the victim's address and word in one granted cycle, then the miss command in the next granted cycle.
- R10: During a miss `cpu_ready` stays low until the cycle after the miss command. It is high for that one cycle, and `bus_req` is low whenever `cpu_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rdata | output | DATA_W | Read word, valid with cpu_ready |
| cpu_ready | output | 1 | Access completes this cycle |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_cmd | output | 2 | Issued command: 00 idle, 01 read miss, 10 write miss, 11 write-back |
| bus_addr | output | ADDR_W | Address of the issued command |
| bus_wdata | output | DATA_W | Word carried by write-back and write miss |
| bus_fill | input | DATA_W | Fill word returned for this node's miss |
| snp_cmd | input | 2 | Command placed by another node (same encoding) |
| snp_addr | input | ADDR_W | Address of the snooped command |
| snp_abort | output | 1 | Memory must not answer; this node supplies the word |
| snp_data | output | DATA_W | Dirty word supplied on a snoop hit |

## Verification
Reads and writes use a handful of tags spread over all indices, so hits, clean misses, upgrades from shared, and dirty-victim replacements all occur. These cases separate the local completion path from the bus path and show whether a write-back comes before the miss. Snoops of every command type are aimed at shared lines, exclusive lines and non-matching tags, which tells a supplying abort apart from a silent invalidation and from no effect at all. Other snoops are injected while a miss waits for its grant, with random grant delay. These show whether the controller re-decides at the grant, for example dropping the victim write-back because a snoop already took the dirty line.

// File: rtl/coh_pkg.sv
package coh_pkg;

   typedef enum logic [1:0] {
      CMD_IDLE   = 2'b00,
      CMD_RDMISS = 2'b01,
      CMD_WRMISS = 2'b10,
      CMD_WBACK  = 2'b11
   } bus_cmd_e;

   typedef enum logic [1:0] {
      LN_INV = 2'b00,
      LN_SHR = 2'b01,
      LN_EXC = 2'b10
   } line_st_e;

   typedef enum logic [1:0] {
      PS_IDLE = 2'b00,
      PS_ARB  = 2'b01,
      PS_DONE = 2'b10
   } proc_st_e;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
   import coh_pkg::*;
#(
   parameter int LINES      = 8,
   parameter int TAG_W      = 9,
   parameter int DATA_W     = 16,
   parameter bit CLEAR_DATA = 1'b1,
   localparam int IDX_W     = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   // processor-side read port
   input  logic [IDX_W-1:0]  c_idx,
   output line_st_e          c_st,
   output logic [TAG_W-1:0]  c_tag,
   output logic [DATA_W-1:0] c_data,
   // snoop-side read port
   input  logic [IDX_W-1:0]  s_idx,
   output line_st_e          s_st,
   output logic [TAG_W-1:0]  s_tag,
   output logic [DATA_W-1:0] s_data,
   // processor-side update
   input  logic              c_meta_we,
   input  line_st_e          c_st_new,
   input  logic [TAG_W-1:0]  c_tag_new,
   input  logic              c_data_we,
   input  logic [DATA_W-1:0] c_data_new,
   // snoop-side state update (wins on a same-index collision)
   input  logic              s_we,
   input  line_st_e          s_st_new
);

   line_st_e          st_q   [LINES];
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [DATA_W-1:0] data_q [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) st_q[i] <= LN_INV;
      end else begin
         if (c_meta_we) st_q[c_idx] <= c_st_new;
         if (s_we)      st_q[s_idx] <= s_st_new;
      end
   end

   always_ff @(posedge clk) begin
      if (c_meta_we) tag_q[c_idx] <= c_tag_new;
   end

   generate
      if (CLEAR_DATA) begin : g_data_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < LINES; i++) data_q[i] <= '0;
            end else if (c_data_we) begin
               data_q[c_idx] <= c_data_new;
            end
         end
      end else begin : g_data_raw
         always_ff @(posedge clk) begin
            if (c_data_we) data_q[c_idx] <= c_data_new;
         end
      end
   endgenerate

   assign c_st   = st_q[c_idx];
   assign c_tag  = tag_q[c_idx];
   assign c_data = data_q[c_idx];
   assign s_st   = st_q[s_idx];
   assign s_tag  = tag_q[s_idx];
   assign s_data = data_q[s_idx];

   // checker state: last snoop update, compared against the array next cycle
   logic             chk_we_q;
   logic [IDX_W-1:0] chk_idx_q;
   line_st_e         chk_st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_we_q  <= 1'b0;
         chk_idx_q <= '0;
         chk_st_q  <= LN_INV;
      end else begin
         chk_we_q  <= s_we;
         chk_idx_q <= s_idx;
         chk_st_q  <= s_st_new;
      end
   end

   // R6: a snoop downgrade is never lost to a same-cycle processor update
   p_snoop_update_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      chk_we_q |-> (st_q[chk_idx_q] == chk_st_q));

endmodule

// File: rtl/coh_snoop_resp.sv
module coh_snoop_resp
   import coh_pkg::*;
#(
   parameter int TAG_W  = 9,
   parameter int DATA_W = 16
) (
   input  bus_cmd_e          snp_cmd,
   input  logic              bus_gnt,
   input  logic [TAG_W-1:0]  snp_tag,
   input  line_st_e          ln_st,
   input  logic [TAG_W-1:0]  ln_tag,
   input  logic [DATA_W-1:0] ln_data,
   output logic              active,
   output logic              abort,
   output logic [DATA_W-1:0] supply,
   output logic              st_we,
   output line_st_e          st_new
);

   logic is_rd, is_wr, hit, dirty;

   always_comb begin
      is_rd  = (snp_cmd == CMD_RDMISS) && !bus_gnt;
      is_wr  = (snp_cmd == CMD_WRMISS) && !bus_gnt;
      active = is_rd || is_wr;
      hit    = (ln_st != LN_INV) && (ln_tag == snp_tag);
      dirty  = hit && (ln_st == LN_EXC);
      abort  = dirty && active;
      supply = abort ? ln_data : '0;
      st_we  = (hit && is_wr) || (dirty && is_rd);
      st_new = is_wr ? LN_INV : LN_SHR;
   end

endmodule

// File: rtl/coh_proc_fsm.sv
module coh_proc_fsm
   import coh_pkg::*;
#(
   parameter int TAG_W  = 9,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [TAG_W-1:0]  cpu_tag,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              snp_conflict,
   input  logic              bus_gnt,
   input  logic [DATA_W-1:0] bus_fill,
   output logic              bus_req,
   output bus_cmd_e          bus_cmd,
   output logic [TAG_W-1:0]  bus_tag,
   output logic [DATA_W-1:0] bus_wdata,
   input  line_st_e          c_st,
   input  logic [TAG_W-1:0]  c_tag,
   input  logic [DATA_W-1:0] c_data,
   output logic              c_meta_we,
   output line_st_e          c_st_new,
   output logic [TAG_W-1:0]  c_tag_new,
   output logic              c_data_we,
   output logic [DATA_W-1:0] c_data_new
);

   proc_st_e state_q, state_d;
   logic     tag_hit, local_ok, need_wb;

   always_comb begin
      tag_hit  = (c_st != LN_INV) && (c_tag == cpu_tag);
      local_ok = tag_hit && (!cpu_we || (c_st == LN_EXC));
      need_wb  = (c_st == LN_EXC) && (c_tag != cpu_tag);
   end

   always_comb begin
      state_d    = state_q;
      cpu_ready  = 1'b0;
      cpu_rdata  = c_data;
      bus_req    = 1'b0;
      bus_cmd    = CMD_IDLE;
      bus_tag    = cpu_tag;
      bus_wdata  = '0;
      c_meta_we  = 1'b0;
      c_st_new   = LN_INV;
      c_tag_new  = cpu_tag;
      c_data_we  = 1'b0;
      c_data_new = cpu_wdata;
      unique case (state_q)
         PS_IDLE: begin
            if (cpu_req && !snp_conflict) begin
               if (local_ok) begin
                  cpu_ready = 1'b1;
                  c_data_we = cpu_we;
               end else begin
                  state_d = PS_ARB;
               end
            end
         end
         PS_ARB: begin
            bus_req = 1'b1;
            if (bus_gnt) begin
               if (need_wb) begin
                  bus_cmd   = CMD_WBACK;
                  bus_tag   = c_tag;
                  bus_wdata = c_data;
                  c_meta_we = 1'b1;
                  c_st_new  = LN_INV;
                  c_tag_new = c_tag;
               end else begin
                  bus_cmd    = cpu_we ? CMD_WRMISS : CMD_RDMISS;
                  bus_wdata  = cpu_we ? cpu_wdata : '0;
                  c_meta_we  = 1'b1;
                  c_st_new   = cpu_we ? LN_EXC : LN_SHR;
                  c_data_we  = 1'b1;
                  c_data_new = cpu_we ? cpu_wdata : bus_fill;
                  state_d    = PS_DONE;
               end
            end
         end
         PS_DONE: begin
            cpu_ready = 1'b1;
            state_d   = PS_IDLE;
         end
         default: state_d = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PS_IDLE;
      else        state_q <= state_d;
   end

   // R4: an exclusive write hit never touches the bus
   p_exc_write_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_IDLE && cpu_req && cpu_we && c_st == LN_EXC &&
       c_tag == cpu_tag && !snp_conflict)
      |-> (cpu_ready && !bus_req && bus_cmd == CMD_IDLE));

   // R8: a miss completes only after a granted cycle
   p_done_after_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_DONE) |-> $past(bus_gnt));

   // R9: a victim write-back is followed by the miss while the grant is held
   p_wb_then_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == CMD_WBACK) |=>
      (!bus_gnt || bus_cmd == CMD_RDMISS || bus_cmd == CMD_WRMISS));

endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
   import coh_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 16,
   parameter int LINES      = 8,
   parameter bit CLEAR_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_fill,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_abort,
   output logic [DATA_W-1:0] snp_data
);

   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   generate
      if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
         $error("LINES must be a power of two, at least 2");
      end
      if (ADDR_W <= IDX_W) begin : g_bad_addr
         $error("ADDR_W must exceed the index width");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   logic [IDX_W-1:0]  cpu_idx, snp_idx;
   logic [TAG_W-1:0]  cpu_tag, snp_tag, bus_tag;
   bus_cmd_e          snp_cmd_e, bus_cmd_e_w;

   line_st_e          c_st, s_st, c_st_new, s_st_new;
   logic [TAG_W-1:0]  c_tag, s_tag, c_tag_new;
   logic [DATA_W-1:0] c_data, s_data, c_data_new;
   logic              c_meta_we, c_data_we, s_we, snp_active;

   assign cpu_idx   = cpu_addr[IDX_W-1:0];
   assign cpu_tag   = cpu_addr[ADDR_W-1:IDX_W];
   assign snp_idx   = snp_addr[IDX_W-1:0];
   assign snp_tag   = snp_addr[ADDR_W-1:IDX_W];
   assign snp_cmd_e = bus_cmd_e'(snp_cmd);
   assign bus_cmd   = bus_cmd_e_w;
   assign bus_addr  = {bus_tag, cpu_idx};

   coh_line_store #(
      .LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .CLEAR_DATA(CLEAR_DATA)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .c_idx(cpu_idx), .c_st(c_st), .c_tag(c_tag), .c_data(c_data),
      .s_idx(snp_idx), .s_st(s_st), .s_tag(s_tag), .s_data(s_data),
      .c_meta_we(c_meta_we), .c_st_new(c_st_new), .c_tag_new(c_tag_new),
      .c_data_we(c_data_we), .c_data_new(c_data_new),
      .s_we(s_we), .s_st_new(s_st_new)
   );

   coh_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
      .snp_cmd(snp_cmd_e), .bus_gnt(bus_gnt), .snp_tag(snp_tag),
      .ln_st(s_st), .ln_tag(s_tag), .ln_data(s_data),
      .active(snp_active), .abort(snp_abort), .supply(snp_data),
      .st_we(s_we), .st_new(s_st_new)
   );

   coh_proc_fsm #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_proc (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_tag(cpu_tag),
      .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .snp_conflict(snp_active && (snp_idx == cpu_idx)),
      .bus_gnt(bus_gnt), .bus_fill(bus_fill),
      .bus_req(bus_req), .bus_cmd(bus_cmd_e_w), .bus_tag(bus_tag),
      .bus_wdata(bus_wdata),
      .c_st(c_st), .c_tag(c_tag), .c_data(c_data),
      .c_meta_we(c_meta_we), .c_st_new(c_st_new), .c_tag_new(c_tag_new),
      .c_data_we(c_data_we), .c_data_new(c_data_new)
   );

   // R5: abort only answers another node's miss, never while granted
   p_abort_on_foreign_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
      snp_abort |-> (!bus_gnt && (snp_cmd == 2'b01 || snp_cmd == 2'b10)));

   // R10: the processor is released only when no bus request is pending
   p_ready_without_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !bus_req);

   // R8: a command is issued only under grant and only in answer to a request
   p_cmd_under_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd != 2'b00) |-> (bus_gnt && bus_req));

endmodule

// File: tb/sim_snoop_coh_ctrl.sv
`timescale 1ns/1ps
module sim_snoop_coh_ctrl;

   localparam int AW = 12;
   localparam int DW = 16;
   localparam int NL = 8;
   localparam int IW = 3;
   localparam int TW = AW - IW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cpu_req, cpu_we;
   logic [AW-1:0] cpu_addr;
   logic [DW-1:0] cpu_wdata, cpu_rdata;
   logic          cpu_ready, bus_req, bus_gnt;
   logic [1:0]    bus_cmd, snp_cmd;
   logic [AW-1:0] bus_addr, snp_addr;
   logic [DW-1:0] bus_wdata, bus_fill, snp_data;
   logic          snp_abort;

   snoop_coh_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL), .CLEAR_DATA(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_fill(bus_fill),
      .snp_cmd(snp_cmd), .snp_addr(snp_addr),
      .snp_abort(snp_abort), .snp_data(snp_data)
   );

   always #2 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // reference state: 0 invalid, 1 shared, 2 exclusive
   int            m_st   [NL];
   logic [TW-1:0] m_tag  [NL];
   logic [DW-1:0] m_data [NL];
   logic [DW-1:0] mem    [int unsigned];

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      logic [31:0] t;
      t = {20'd0, a} * 32'd40503 + 32'h1D3;
      return t[DW-1:0];
   endfunction

   function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
      if (mem.exists(int'(a))) return mem[int'(a)];
      return pat(a);
   endfunction

   function automatic logic [AW-1:0] mk(input int t, input int i);
      logic [TW-1:0] tt;
      logic [IW-1:0] ii;
      tt = TW'(t);
      ii = IW'(i);
      return {tt, ii};
   endfunction

   always @(negedge clk) bus_fill <= mem_rd(bus_addr);

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic snoop_cyc(input logic [1:0] cmd, input logic [AW-1:0] a);
      int   ix;
      logic hit, ex_ab;
      string rq;
      ix    = int'(a[IW-1:0]);
      hit   = (m_st[ix] != 0) && (m_tag[ix] == a[AW-1:IW]);
      ex_ab = hit && (m_st[ix] == 2) && (cmd == 2'b01 || cmd == 2'b10);
      if (cmd == 2'b10 && hit)                       rq = "R6";
      else if (cmd == 2'b01 && hit && m_st[ix] == 2) rq = "R5";
      else                                           rq = "R7";
      @(negedge clk);
      snp_cmd  = cmd;
      snp_addr = a;
      #1;
      chk(rq, 32'(snp_abort), 32'(ex_ab));
      if (ex_ab) begin
         chk(rq, 32'(snp_data), 32'(m_data[ix]));
         mem[int'(a)] = m_data[ix];
      end
      if (hit && cmd == 2'b10) m_st[ix] = 0;
      else if (hit && cmd == 2'b01 && m_st[ix] == 2) m_st[ix] = 1;
      @(posedge clk);
      #1 snp_cmd = 2'b00;
   endtask

   task automatic do_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input bit inj, input logic [1:0] scmd, input logic [AW-1:0] sa);
      int            ix, d;
      logic [TW-1:0] tg, vt;
      bit            hit, loc, vwb;
      logic [DW-1:0] ex;
      string         rq;
      ix = int'(a[IW-1:0]);
      tg = a[AW-1:IW];
      rq = we ? "R3" : "R2";
      @(negedge clk);
      cpu_req   = 1'b1;
      cpu_we    = we;
      cpu_addr  = a;
      cpu_wdata = wd;
      #1;
      hit = (m_st[ix] != 0) && (m_tag[ix] == tg);
      loc = hit && (!we || m_st[ix] == 2);
      if (loc) begin
         chk(we ? "R4" : "R2", 32'(cpu_ready), 32'd1);
         chk(we ? "R4" : "R2", 32'(bus_req), 32'd0);
         chk(we ? "R4" : "R2", 32'(bus_cmd), 32'd0);
         if (!we) chk("R2", 32'(cpu_rdata), 32'(m_data[ix]));
         @(posedge clk);
         #1 cpu_req = 1'b0;
         if (we) m_data[ix] = wd;
      end else begin
         chk("R10", 32'(cpu_ready), 32'd0);
         @(posedge clk);
         if (inj) snoop_cyc(scmd, sa);
         d = $urandom_range(0, 3);
         repeat (d) begin
            @(negedge clk);
            #1;
            chk("R8", 32'(bus_req), 32'd1);
            chk("R8", 32'(bus_cmd), 32'd0);
            @(posedge clk);
         end
         vwb = (m_st[ix] == 2) && (m_tag[ix] != tg);
         @(negedge clk);
         bus_gnt = 1'b1;
         #1;
         if (vwb) begin
            vt = m_tag[ix];
            chk("R9", 32'(bus_cmd), 32'd3);
            chk("R9", 32'({vt, a[IW-1:0]}), 32'(bus_addr));
            chk("R9", 32'(bus_wdata), 32'(m_data[ix]));
            chk("R10", 32'(cpu_ready), 32'd0);
            mem[int'({vt, a[IW-1:0]})] = m_data[ix];
            m_st[ix] = 0;
            @(posedge clk);
            @(negedge clk);
            #1;
         end
         ex = we ? wd : mem_rd(a);
         chk(rq, 32'(bus_cmd), we ? 32'd2 : 32'd1);
         chk(rq, 32'(bus_addr), 32'(a));
         @(posedge clk);
         m_st[ix]   = we ? 2 : 1;
         m_tag[ix]  = tg;
         m_data[ix] = ex;
         @(negedge clk);
         bus_gnt = 1'b0;
         #1;
         chk("R10", 32'(cpu_ready), 32'd1);
         chk("R10", 32'(bus_req), 32'd0);
         chk(rq, 32'(cpu_rdata), 32'(ex));
         @(posedge clk);
         #1 cpu_req = 1'b0;
      end
   endtask

   initial begin
      void'($urandom(32'd2024));
      rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
      bus_gnt = 1'b0; snp_cmd = 2'b00; snp_addr = '0;
      for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = '0; m_data[i] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk("R1", 32'(cpu_ready), 32'd0);
      chk("R1", 32'(bus_req), 32'd0);
      chk("R1", 32'(bus_cmd), 32'd0);
      chk("R1", 32'(snp_abort), 32'd0);

      // R1/R2: first read misses, second hits
      do_op(1'b0, mk(0, 1), '0, 1'b0, 2'b00, '0);
      do_op(1'b0, mk(0, 1), '0, 1'b0, 2'b00, '0);
      // R3 upgrade from shared, R4 local write, read back
      do_op(1'b1, mk(0, 1), 16'hBEEF, 1'b0, 2'b00, '0);
      do_op(1'b1, mk(0, 1), 16'h1234, 1'b0, 2'b00, '0);
      do_op(1'b0, mk(0, 1), '0, 1'b0, 2'b00, '0);
      // R5 supply on read snoop, then R7 no-effect snoops, state shown by a hit
      snoop_cyc(2'b01, mk(0, 1));
      snoop_cyc(2'b01, mk(0, 1));
      snoop_cyc(2'b10, mk(5, 1));
      snoop_cyc(2'b11, mk(0, 1));
      do_op(1'b0, mk(0, 1), '0, 1'b0, 2'b00, '0);
      // R6 invalidation, then a miss refetches the supplied word
      snoop_cyc(2'b10, mk(0, 1));
      do_op(1'b0, mk(0, 1), '0, 1'b0, 2'b00, '0);
      // R9 dirty victim written back before the miss
      do_op(1'b1, mk(1, 2), 16'hA5A5, 1'b0, 2'b00, '0);
      do_op(1'b0, mk(2, 2), '0, 1'b0, 2'b00, '0);
      // R8: snoop takes the dirty victim while waiting, no write-back follows
      do_op(1'b1, mk(1, 3), 16'h0077, 1'b0, 2'b00, '0);
      do_op(1'b0, mk(2, 3), '0, 1'b1, 2'b10, mk(1, 3));
      // R8: pending upgrade with a read snoop, and with an invalidating snoop
      do_op(1'b0, mk(0, 4), '0, 1'b0, 2'b00, '0);
      do_op(1'b1, mk(0, 4), 16'h0055, 1'b1, 2'b01, mk(0, 4));
      do_op(1'b0, mk(0, 5), '0, 1'b0, 2'b00, '0);
      do_op(1'b1, mk(0, 5), 16'h0066, 1'b1, 2'b10, mk(0, 5));

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         logic [AW-1:0] ra, sa;
         ra = mk($urandom_range(0, 2), $urandom_range(0, NL - 1));
         sa = mk($urandom_range(0, 2), $urandom_range(0, NL - 1));
         if ($urandom_range(0, 4) == 0)
            snoop_cyc(2'($urandom_range(0, 3)), sa);
         else
            do_op(1'($urandom_range(0, 1)), ra, 16'($urandom()),
                  ($urandom_range(0, 3) == 0), 2'($urandom_range(0, 3)), sa);
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule